// File: doc/BRIEF.md
# Wrap-Safe One-Shot Deadline Timer

This block keeps a 64-bit tick count that starts from zero after reset and advances by one on every clock. Next to it sits a single deadline register with an armed flag. When the count lands exactly on the stored deadline, a pending flag is set and the trigger disarms itself, so it fires once. The pending flag drives the interrupt line and stays set until software clears it.

Software loads a deadline in one of two ways. It can write an absolute tick value, or it can write an increment that the hardware adds to the live count. Software does not need to read the count first for the second form. All the hard work happens on the write. The new deadline minus the live count is taken as a signed 64-bit number. If that number is zero or negative, the deadline has already passed and the interrupt is latched on that same write. Because of this, the per-cycle detector only needs an equality compare, and it stays correct across a counter wrap.

A 32-bit register port reaches everything. For 64-bit values, the upper word is staged and the lower word commits the pair. Reads of a lower word capture the matching upper word, so the following upper-word read is consistent with it.

Top module: `tick_deadline_timer`

## Requirements
- R1: The tick count is 0 after reset, grows by exactly one per clock and wraps modulo 2^64. Reading address 0 returns its low 32 bits in the same cycle.
- R2: A read of address 0 copies count bits 63:32 into a holding word. A read of address 2 copies deadline bits 63:32 into it, and returns deadline bits 31:0. Reads of address 1 or 3 return the holding word. Reads of addresses 4, 5 and 7 return 0.
- R3: A write to address 3 or 5 stores wdata as the staged upper word and clears the armed flag. A trigger armed before such a write does not fire afterwards.
- R4: A write to address 2 stores {staged word, wdata} as the deadline. If that 64-bit value is zero, the trigger ends disarmed and the pending flag is not set by the write.
- R5: A write to address 4 stores count + {staged word, wdata} as the deadline. The count used is the value in the cycle of the write, and the sum is taken modulo 2^64.
- R6: For a non-zero committed deadline D and count C, if (D - C) read as signed 64-bit is zero or negative, the pending flag is set by that write and the trigger stays disarmed. Otherwise the trigger becomes armed.
- R7: While armed, a cycle in which the count equals the deadline sets the pending flag and disarms the trigger.
- R8: Address 6 is the control word: bit 0 is pending and bit 1 is armed. Writing it with bit 0 = 1 clears pending, and writing it with bit 0 = 0 leaves pending alone. A set event in the same cycle takes priority over the clear.
- R9: If a deadline commit lands in the cycle of a match, pending is set. The armed flag then follows the new commit alone.
- R10: irq_o equals the pending flag, one clock after the event that sets or clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (captures upper words) |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Interrupt, equal to the pending flag |

## Verification
Read data is combinational, so the bench compares it in the cycle of the read. The holding word and staged word take effect at the edge that ends the access, so they are checked on the next access. Pending, armed and irq_o change at the clock edge that consumes a write or a match. The behavioural model therefore advances at each rising edge, and irq_o is compared against it at the falling edge that follows. The corner cases are driven at exact cycles so that each one lands where intended: increments of 0 and 1, the signed 2^63 boundary, a zero absolute deadline, an upper-word write between arm and match, and a commit or a clear that coincides with a match.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

   typedef enum logic [2:0] {
      A_CNT_LO = 3'd0,
      A_CNT_HI = 3'd1,
      A_DL_LO  = 3'd2,
      A_DL_HI  = 3'd3,
      A_REL_LO = 3'd4,
      A_REL_HI = 3'd5,
      A_CTRL   = 3'd6
   } tdc_addr_e;

   // decoded write intent handed from the port to the trigger
   typedef struct packed {
      logic commit_abs;
      logic commit_rel;
      logic stage_hi;
      logic clr_pend;
   } tdc_cmd_t;

endpackage

// File: rtl/tdc_counter.sv
module tdc_counter #(
   parameter int CNT_W = 64
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [CNT_W-1:0] cnt_o
);

   always_ff @(posedge clk_i) begin
      if (rst_i) cnt_o <= '0;
      else       cnt_o <= cnt_o + CNT_W'(1);
   end

   assert_count_step_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

endmodule

// File: rtl/tdc_port.sv
module tdc_port
   import tdc_pkg::*;
#(
   parameter int CNT_W    = 64,
   parameter int BUS_W    = 32,
   parameter bit READ_REG = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             wr_en_i,
   input  logic             rd_en_i,
   input  logic [2:0]       addr_i,
   input  logic [BUS_W-1:0] wdata_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] dl_i,
   input  logic             armed_i,
   input  logic             pend_i,
   output logic [BUS_W-1:0] rdata_o,
   output tdc_cmd_t         cmd_o,
   output logic [BUS_W-1:0] stage_o
);

   localparam int HI_LSB = CNT_W - BUS_W;

   tdc_addr_e        a;
   logic [BUS_W-1:0] hold_q;
   logic [BUS_W-1:0] rd_mux;

   assign a = tdc_addr_e'(addr_i);

   always_comb begin
      cmd_o            = '0;
      cmd_o.commit_abs = wr_en_i && (a == A_DL_LO);
      cmd_o.commit_rel = wr_en_i && (a == A_REL_LO);
      cmd_o.stage_hi   = wr_en_i && ((a == A_DL_HI) || (a == A_REL_HI));
      cmd_o.clr_pend   = wr_en_i && (a == A_CTRL) && wdata_i[0];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         stage_o <= '0;
         hold_q  <= '0;
      end else begin
         if (cmd_o.stage_hi) stage_o <= wdata_i;
         if (rd_en_i && (a == A_CNT_LO)) hold_q <= cnt_i[CNT_W-1:HI_LSB];
         else if (rd_en_i && (a == A_DL_LO)) hold_q <= dl_i[CNT_W-1:HI_LSB];
      end
   end

   always_comb begin
      rd_mux = '0;
      case (a)
         A_CNT_LO: rd_mux = cnt_i[BUS_W-1:0];
         A_CNT_HI: rd_mux = hold_q;
         A_DL_LO:  rd_mux = dl_i[BUS_W-1:0];
         A_DL_HI:  rd_mux = hold_q;
         A_CTRL:   rd_mux = {{(BUS_W-2){1'b0}}, armed_i, pend_i};
         default:  rd_mux = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk_i) begin
            if (rst_i)        rdata_o <= '0;
            else if (rd_en_i) rdata_o <= rd_mux;
         end
      end else begin : g_rd_comb
         assign rdata_o = rd_en_i ? rd_mux : '0;
      end
   endgenerate

endmodule

// File: rtl/tdc_trigger.sv
module tdc_trigger
   import tdc_pkg::*;
#(
   parameter int CNT_W = 64,
   parameter int BUS_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  tdc_cmd_t         cmd_i,
   input  logic [BUS_W-1:0] stage_i,
   input  logic [BUS_W-1:0] wlo_i,
   output logic [CNT_W-1:0] dl_o,
   output logic             armed_o,
   output logic             pend_o
);

   logic [CNT_W-1:0] wide_val;
   logic [CNT_W-1:0] new_dl;
   logic [CNT_W-1:0] diff;
   logic             commit;
   logic             expired;
   logic             zero_off;
   logic             hit;
   logic             set_ev;

   assign wide_val = {stage_i, wlo_i};
   assign new_dl   = cmd_i.commit_rel ? (cnt_i + wide_val) : wide_val;
   assign diff     = new_dl - cnt_i;
   // signed difference at or below zero: already reached (wrap-safe)
   assign expired  = diff[CNT_W-1] | ~|diff;
   assign commit   = cmd_i.commit_abs | cmd_i.commit_rel;
   assign zero_off = cmd_i.commit_abs & ~|wide_val;
   assign hit      = armed_o & (cnt_i == dl_o);
   assign set_ev   = hit | (commit & expired & ~zero_off);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         dl_o    <= '0;
         armed_o <= 1'b0;
         pend_o  <= 1'b0;
      end else begin
         if (commit) dl_o <= new_dl;
         if (commit)              armed_o <= ~zero_off & ~expired;
         else if (cmd_i.stage_hi) armed_o <= 1'b0;
         else if (hit)            armed_o <= 1'b0;
         pend_o <= set_ev | (pend_o & ~cmd_i.clr_pend);
      end
   end

   assert_hi_disarm_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      cmd_i.stage_hi |=> !armed_o);

   assert_zero_off_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (cmd_i.commit_abs && (wide_val == '0)) |=> !armed_o);

   assert_rel_zero_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (cmd_i.commit_rel && (wide_val == '0)) |=> (pend_o && !armed_o));

   assert_match_fire_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (armed_o && (cnt_i == dl_o) && !cmd_i.commit_abs && !cmd_i.commit_rel)
      |=> (pend_o && !armed_o));

   assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (armed_o && (cnt_i == dl_o) && cmd_i.clr_pend) |=> pend_o);

endmodule

// File: rtl/tick_deadline_timer.sv
module tick_deadline_timer
   import tdc_pkg::*;
#(
   parameter int CNT_W    = 64,
   parameter int BUS_W    = 32,
   parameter bit READ_REG = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             wr_en_i,
   input  logic             rd_en_i,
   input  logic [2:0]       addr_i,
   input  logic [BUS_W-1:0] wdata_i,
   output logic [BUS_W-1:0] rdata_o,
   output logic             irq_o
);

   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad_split
         $error("CNT_W must be exactly twice BUS_W");
      end
      if (BUS_W < 2) begin : g_bad_bus
         $error("BUS_W must hold the two control bits");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] dl;
   logic             armed;
   logic             pend;
   logic [BUS_W-1:0] stage;
   tdc_cmd_t         cmd;

   tdc_counter #(.CNT_W(CNT_W)) i_counter (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .cnt_o (cnt)
   );

   tdc_port #(.CNT_W(CNT_W), .BUS_W(BUS_W), .READ_REG(READ_REG)) i_port (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .wr_en_i (wr_en_i),
      .rd_en_i (rd_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .cnt_i   (cnt),
      .dl_i    (dl),
      .armed_i (armed),
      .pend_i  (pend),
      .rdata_o (rdata_o),
      .cmd_o   (cmd),
      .stage_o (stage)
   );

   tdc_trigger #(.CNT_W(CNT_W), .BUS_W(BUS_W)) i_trigger (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .cnt_i   (cnt),
      .cmd_i   (cmd),
      .stage_i (stage),
      .wlo_i   (wdata_i),
      .dl_o    (dl),
      .armed_o (armed),
      .pend_o  (pend)
   );

   assign irq_o = pend;

endmodule

// File: tb/test_tick_deadline_timer.sv
`timescale 1ns/1ps
module test_tick_deadline_timer;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   bit [63:0] m_cnt, m_dl;
   bit [31:0] m_stage, m_hold;
   bit        m_arm, m_pend;

   always #2.5 clk = ~clk;

   tick_deadline_timer i_tick_deadline_timer (
      .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   task automatic check(input bit ok, input string req, input bit [63:0] act, input bit [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit passed(input bit [63:0] d, input bit [63:0] c);
      longint df;
      df = longint'(d - c);
      return df <= 0;
   endfunction

   // one clock: drive at negedge, check read, model the edge, check irq
   task automatic op(input bit w, input bit r, input bit [2:0] a, input bit [31:0] d, input string req);
      bit [31:0] exp;
      bit        fire, setp, clr, narm;
      bit [63:0] nd;
      wr_en = w; rd_en = r; addr = a; wdata = d;
      #1;
      if (r) begin
         case (a)
            3'd0: exp = m_cnt[31:0];
            3'd1, 3'd3: exp = m_hold;
            3'd2: exp = m_dl[31:0];
            3'd6: exp = {30'd0, m_arm, m_pend};
            default: exp = 32'd0;
         endcase
         check(rdata == exp, req, 64'(rdata), 64'(exp));
      end
      @(posedge clk);
      fire = m_arm && (m_cnt == m_dl);
      setp = fire; clr = 1'b0;
      narm = fire ? 1'b0 : m_arm;
      if (w) begin
         case (a)
            3'd3, 3'd5: begin m_stage = d; narm = 1'b0; end
            3'd2, 3'd4: begin
               nd = {m_stage, d};
               if (a == 3'd4) nd = m_cnt + nd;
               m_dl = nd;
               if (a == 3'd2 && nd == 64'd0) narm = 1'b0;
               else if (passed(nd, m_cnt)) begin setp = 1'b1; narm = 1'b0; end
               else narm = 1'b1;
            end
            3'd6: clr = d[0];
            default: ;
         endcase
      end
      if (r && a == 3'd0) m_hold = m_cnt[63:32];
      if (r && a == 3'd2) m_hold = m_dl[63:32];
      m_pend = setp ? 1'b1 : (clr ? 1'b0 : m_pend);
      m_arm  = narm;
      m_cnt  = m_cnt + 64'd1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check(irq == m_pend, "R10", 64'(irq), 64'(m_pend));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) op(1'b0, 1'b0, 3'd0, 32'd0, "R7");
   endtask

   task automatic status(input string req);
      op(1'b0, 1'b1, 3'd6, 32'd0, req);
   endtask

   task automatic rel_arm(input bit [31:0] hi, input bit [31:0] lo, input string req);
      op(1'b1, 1'b0, 3'd5, hi, req);
      op(1'b1, 1'b0, 3'd4, lo, req);
   endtask

   task automatic clear_pend();
      op(1'b1, 1'b0, 3'd6, 32'd1, "R8");
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_cnt = 0; m_dl = 0; m_stage = 0; m_hold = 0; m_arm = 0; m_pend = 0;
      check(irq == 1'b0, "R10", 64'(irq), 64'd0);
      // R1 reset state and counting
      status("R8");
      op(1'b0, 1'b1, 3'd0, 32'd0, "R1");
      op(1'b0, 1'b1, 3'd1, 32'd0, "R2");
      idle(3);
      op(1'b0, 1'b1, 3'd0, 32'd0, "R1");
      op(1'b0, 1'b1, 3'd7, 32'd0, "R2");
      // R4 absolute future deadline then R7 match
      op(1'b1, 1'b0, 3'd3, 32'd0, "R3");
      op(1'b1, 1'b0, 3'd2, m_cnt[31:0] + 32'd10, "R4");
      status("R6");
      idle(12);
      status("R7");
      // R8 write of zero bit keeps pending, then clear
      op(1'b1, 1'b0, 3'd6, 32'd2, "R8");
      status("R8");
      clear_pend();
      status("R8");
      // R6 absolute deadline already passed
      op(1'b1, 1'b0, 3'd2, 32'd2, "R6");
      status("R6");
      clear_pend();
      // R4 zero absolute disables an armed trigger
      rel_arm(32'd0, 32'd100, "R5");
      status("R5");
      op(1'b1, 1'b0, 3'd3, 32'd0, "R4");
      op(1'b1, 1'b0, 3'd2, 32'd0, "R4");
      status("R4");
      idle(110);
      status("R4");
      // R5 relative increments 0 and 1
      rel_arm(32'd0, 32'd0, "R5");
      status("R5");
      clear_pend();
      rel_arm(32'd0, 32'd1, "R5");
      idle(1);
      status("R5");
      clear_pend();
      // R6 signed boundary
      rel_arm(32'h8000_0000, 32'd0, "R6");
      status("R6");
      clear_pend();
      rel_arm(32'h7FFF_FFFF, 32'hFFFF_FFFF, "R6");
      status("R6");
      idle(4);
      // R3 upper write cancels an armed trigger
      rel_arm(32'd0, 32'd6, "R3");
      idle(2);
      op(1'b1, 1'b0, 3'd3, 32'd0, "R3");
      idle(10);
      status("R3");
      // R9 commit in match cycle: expired commit
      rel_arm(32'd0, 32'd4, "R9");
      idle(3);
      op(1'b1, 1'b0, 3'd4, 32'd0, "R9");
      status("R9");
      clear_pend();
      // R9 commit in match cycle: future commit stays armed
      rel_arm(32'd0, 32'd4, "R9");
      idle(3);
      op(1'b1, 1'b0, 3'd4, 32'd50, "R9");
      status("R9");
      clear_pend();
      idle(55);
      status("R9");
      clear_pend();
      // R8 set wins over a clear in the match cycle
      rel_arm(32'd0, 32'd3, "R8");
      idle(2);
      clear_pend();
      status("R8");
      clear_pend();
      // R2 holding word keeps the captured upper half
      op(1'b1, 1'b0, 3'd3, 32'hABCD_0123, "R2");
      op(1'b1, 1'b0, 3'd2, 32'h11, "R2");
      op(1'b0, 1'b1, 3'd2, 32'd0, "R2");
      op(1'b1, 1'b0, 3'd3, 32'h5555, "R2");
      op(1'b1, 1'b0, 3'd2, 32'h22, "R2");
      op(1'b0, 1'b1, 3'd3, 32'd0, "R2");
      op(1'b0, 1'b1, 3'd2, 32'd0, "R2");
      op(1'b0, 1'b1, 3'd3, 32'd0, "R2");
      op(1'b0, 1'b1, 3'd0, 32'd0, "R1");
      op(1'b0, 1'b1, 3'd1, 32'd0, "R2");
      op(1'b0, 1'b1, 3'd5, 32'd0, "R2");
      status("R8");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule